// File: doc/BRIEF.md
# Programmable Parallel Port Register Block

This block is the bus-facing register set of a general-purpose parallel I/O device with three 8-bit ports, named A, B and C. A CPU reaches it through an 8-bit write-data bus, an 8-bit read-data bus with an output enable, active-low chip select, read and write strobes, and a 2-bit select that picks a port or the control register. Each port presents a latched output value and a per-bit output enable, which together drive a tristate pad outside this block. Pad levels come back on a separate input bus.

The control register takes two kinds of command, told apart by bit 7. A mode word (bit 7 set) sets the direction of port A, port B and each half of port C for plain unhandshaked I/O. A single-line command (bit 7 clear) sets or clears one port C output latch bit. Port C's two 4-bit halves take their directions independently. Data on an input port is not latched: a read returns the current pad levels.

All state is held in flops on one clock. A write takes effect on the first clock edge on which chip select and the write strobe are both low. Reads are combinational.

Top module: `ppio_regs`

## Requirements
- R1: After reset, all three output latches hold 0x00, every output enable is low, and the control register reads back 0x9B (every port an input).
- R2: Select 00 reaches port A, 01 port B, 10 port C and 11 the control register, for both reads and writes.
- R3: A write is accepted only while cs_n and wr_n are both low. It is committed once, with the data present at the first rising clock edge of that low period, and shows on the outputs right after that edge. Later edges of the same strobe and writes with cs_n high change nothing.
- R4: rdata_oe is high exactly while cs_n and rd_n are both low. The selected value appears on rdata in the same cycle, and rdata is 0x00 at all other times.
- R5: A mode word has bit 7 = 1 and sets directions, with 1 meaning input: bit 4 for port A, bit 1 for port B, bit 3 for port C bits 7:4 and bit 0 for port C bits 3:0. Each output enable bit is high exactly when its port or half is an output. For example, 0x8B makes only A an output, 0x89 makes A and B outputs, and 0x99 makes only B an output.
- R6: An accepted mode word clears all three output latches to 0x00.
- R7: A mode word with bit 6, bit 5 or bit 2 set is rejected. It leaves the directions, the stored mode word and every latch unchanged.
- R8: A control write with bit 7 = 0 writes bit 0 into the port C latch line chosen by bits 3:1. For example, 0x0D sets line 6, 0x05 sets line 2 and 0x0C clears line 6. Bits 6:4 are ignored, and no other latch bit changes.
- R9: A read of a port, or of a port C half, that is set as an input returns the current pad levels. If it is set as an output, the read returns its latch.
- R10: A data write to a port set as an input still loads its latch, which shows on its output bus while its output enable stays low.
- R11: A read of the control register returns the last accepted mode word. Single-line commands do not alter this value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cs_n | input | 1 | Chip select, active low |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low |
| sel | input | 2 | Register select: A, B, C, control |
| wdata | input | 8 | Write data from CPU |
| rdata | output | 8 | Read data to CPU, zero when idle |
| rdata_oe | output | 1 | High while read data is driven |
| pa_in | input | 8 | Port A pad levels |
| pa_out | output | 8 | Port A output latch |
| pa_oe | output | 8 | Port A output enables |
| pb_in | input | 8 | Port B pad levels |
| pb_out | output | 8 | Port B output latch |
| pb_oe | output | 8 | Port B output enables |
| pc_in | input | 8 | Port C pad levels |
| pc_out | output | 8 | Port C output latch |
| pc_oe | output | 8 | Port C output enables, one per half |

## Verification
Mode words are tried in several patterns: all inputs, A only as an output, A and B as outputs, B only as an output, and split halves of port C. Each pattern tells a swapped direction bit apart by the resulting output enables and by whether a read returns pad levels or the latch. Single-line commands that set, clear and carry junk in bits 6:4 separate correct line decoding from neighbouring-bit damage. Rejected mode words, writes with chip select high and a long write strobe with changing data separate a correct write qualifier from a level-sensitive or unguarded one.

// File: rtl/ppio_pkg.sv
package ppio_pkg;

    localparam int DATA_W    = 8;
    localparam int HALF_W    = DATA_W / 2;
    localparam int LINE_W    = $clog2(DATA_W);
    localparam int NUM_PORTS = 3;
    localparam int SEL_W     = 2;

    localparam logic [SEL_W-1:0] SEL_A    = 2'b00;
    localparam logic [SEL_W-1:0] SEL_B    = 2'b01;
    localparam logic [SEL_W-1:0] SEL_C    = 2'b10;
    localparam logic [SEL_W-1:0] SEL_CTRL = 2'b11;

    // Command word field positions
    localparam int CMD_KIND_BIT = 7;
    localparam int DIR_A_BIT    = 4;
    localparam int DIR_CHI_BIT  = 3;
    localparam int DIR_B_BIT    = 1;
    localparam int DIR_CLO_BIT  = 0;

    localparam logic [DATA_W-1:0] MODE_AT_RESET = 8'h9B;

    typedef struct packed {
        logic a_in;
        logic b_in;
        logic chi_in;
        logic clo_in;
    } dir_t;

    function automatic logic mode_word_ok(input logic [DATA_W-1:0] w);
        return w[CMD_KIND_BIT] && (w[6:5] == 2'b00) && !w[2];
    endfunction

    function automatic dir_t mode_dirs(input logic [DATA_W-1:0] w);
        dir_t d;
        d.a_in   = w[DIR_A_BIT];
        d.b_in   = w[DIR_B_BIT];
        d.chi_in = w[DIR_CHI_BIT];
        d.clo_in = w[DIR_CLO_BIT];
        return d;
    endfunction

endpackage

// File: rtl/ppio_strobe.sv
module ppio_strobe (
    input  logic clk,
    input  logic rst_n,
    input  logic cs_n,
    input  logic wr_n,
    output logic wr_pulse
);

    typedef struct packed {
        logic held;
    } strobe_st_t;

    strobe_st_t st_d, st_q;
    logic       wr_active;

    always_comb begin
        st_d      = st_q;
        wr_active = !cs_n && !wr_n;
        st_d.held = wr_active;
        wr_pulse  = wr_active && !st_q.held;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R3
    single_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_pulse |=> !wr_pulse);

    // R3
    cs_guard_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |-> !wr_pulse);

endmodule

// File: rtl/ppio_ctrl.sv
module ppio_ctrl
    import ppio_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_pulse,
    input  logic [SEL_W-1:0]  sel,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] mode_word,
    output dir_t              dirs,
    output logic              clr_all,
    output logic              line_en,
    output logic [LINE_W-1:0] line_idx,
    output logic              line_val
);

    typedef struct packed {
        logic [DATA_W-1:0] mode;
    } ctrl_st_t;

    ctrl_st_t st_d, st_q;
    logic     ctrl_wr;
    logic     is_mode;

    always_comb begin
        st_d     = st_q;
        ctrl_wr  = wr_pulse && (sel == SEL_CTRL);
        is_mode  = wdata[CMD_KIND_BIT];
        clr_all  = ctrl_wr && is_mode && mode_word_ok(wdata);
        line_en  = ctrl_wr && !is_mode;
        line_idx = wdata[LINE_W:1];
        line_val = wdata[0];
        if (clr_all) st_d.mode = wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{mode: MODE_AT_RESET};
        else        st_q <= st_d;
    end

    assign mode_word = st_q.mode;
    assign dirs      = mode_dirs(st_q.mode);

    // R5
    mode_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_pulse && sel == SEL_CTRL && wdata[7] && wdata[6:5] == 2'b00 && !wdata[2])
        |=> (mode_word == $past(wdata)));

    // R7
    bad_mode_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_pulse && sel == SEL_CTRL && wdata[7] && (wdata[6] || wdata[5] || wdata[2]))
        |=> $stable(mode_word));

    // R11
    line_cmd_keeps_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_pulse && sel == SEL_CTRL && !wdata[7]) |=> $stable(mode_word));

endmodule

// File: rtl/ppio_latch.sv
module ppio_latch #(
    parameter int W      = 8,
    parameter int IDX_W  = $clog2(W)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             load,
    input  logic [W-1:0]     load_val,
    input  logic             bit_en,
    input  logic [IDX_W-1:0] bit_idx,
    input  logic             bit_val,
    output logic [W-1:0]     q
);

    typedef struct packed {
        logic [W-1:0] val;
    } latch_st_t;

    latch_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (clr)         st_d.val          = '0;
        else if (load)   st_d.val          = load_val;
        else if (bit_en) st_d.val[bit_idx] = bit_val;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign q = st_q.val;

    // R6
    clear_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (q == '0));

    // R8
    line_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_en && !clr && !load) |=> (q[$past(bit_idx)] == $past(bit_val)));

    // R8
    line_neighbours_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_en && !clr && !load)
        |=> (((q ^ $past(q)) & ~(W'(1) << $past(bit_idx))) == '0));

    // R3
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && !load && !bit_en) |=> $stable(q));

endmodule

// File: rtl/ppio_regs.sv
module ppio_regs
    import ppio_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic              rd_n,
    input  logic              wr_n,
    input  logic [1:0]        sel,
    input  logic [7:0]        wdata,
    output logic [7:0]        rdata,
    output logic              rdata_oe,
    input  logic [7:0]        pa_in,
    output logic [7:0]        pa_out,
    output logic [7:0]        pa_oe,
    input  logic [7:0]        pb_in,
    output logic [7:0]        pb_out,
    output logic [7:0]        pb_oe,
    input  logic [7:0]        pc_in,
    output logic [7:0]        pc_out,
    output logic [7:0]        pc_oe
);

    localparam int PORT_C_IDX = 2;

    logic              wr_pulse;
    logic [DATA_W-1:0] mode_word;
    dir_t              dirs;
    logic              clr_all;
    logic              line_en;
    logic [LINE_W-1:0] line_idx;
    logic              line_val;
    logic [DATA_W-1:0] latch_q [NUM_PORTS];
    logic [DATA_W-1:0] rd_mux;

    ppio_strobe u_strobe (
        .clk      (clk),
        .rst_n    (rst_n),
        .cs_n     (cs_n),
        .wr_n     (wr_n),
        .wr_pulse (wr_pulse)
    );

    ppio_ctrl u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_pulse  (wr_pulse),
        .sel       (sel),
        .wdata     (wdata),
        .mode_word (mode_word),
        .dirs      (dirs),
        .clr_all   (clr_all),
        .line_en   (line_en),
        .line_idx  (line_idx),
        .line_val  (line_val)
    );

    for (genvar i = 0; i < NUM_PORTS; i++) begin : g_port
        ppio_latch #(.W(DATA_W)) u_latch (
            .clk      (clk),
            .rst_n    (rst_n),
            .clr      (clr_all),
            .load     (wr_pulse && (sel == SEL_W'(i))),
            .load_val (wdata),
            .bit_en   ((i == PORT_C_IDX) ? line_en : 1'b0),
            .bit_idx  (line_idx),
            .bit_val  (line_val),
            .q        (latch_q[i])
        );
    end

    assign pa_out = latch_q[0];
    assign pb_out = latch_q[1];
    assign pc_out = latch_q[PORT_C_IDX];

    assign pa_oe = {DATA_W{!dirs.a_in}};
    assign pb_oe = {DATA_W{!dirs.b_in}};
    assign pc_oe = {{HALF_W{!dirs.chi_in}}, {HALF_W{!dirs.clo_in}}};

    always_comb begin
        rd_mux = '0;
        case (sel)
            SEL_A: rd_mux = dirs.a_in ? pa_in : latch_q[0];
            SEL_B: rd_mux = dirs.b_in ? pb_in : latch_q[1];
            SEL_C: begin
                rd_mux[DATA_W-1:HALF_W] = dirs.chi_in ? pc_in[DATA_W-1:HALF_W]
                                                      : latch_q[PORT_C_IDX][DATA_W-1:HALF_W];
                rd_mux[HALF_W-1:0]      = dirs.clo_in ? pc_in[HALF_W-1:0]
                                                      : latch_q[PORT_C_IDX][HALF_W-1:0];
            end
            default: rd_mux = mode_word;
        endcase
    end

    assign rdata_oe = !cs_n && !rd_n;
    assign rdata    = rdata_oe ? rd_mux : '0;

    // R4
    read_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_n || rd_n) |-> (rdata == 8'h00 && !rdata_oe));

    // R5
    half_uniform_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($countones(pc_oe[7:4]) inside {0, 4}) && ($countones(pc_oe[3:0]) inside {0, 4}));

    // R9
    input_passthru_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs_n && !rd_n && sel == 2'b00 && pa_oe == 8'h00) |-> (rdata == pa_in));

    // R6
    clear_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_pulse && sel == 2'b11 && wdata[7] && wdata[6:5] == 2'b00 && !wdata[2])
        |=> (pa_out == 8'h00 && pb_out == 8'h00 && pc_out == 8'h00));

endmodule

// File: tb/ppio_regs_bench.sv
`timescale 1ns/1ps
module ppio_regs_bench;

    localparam int OBS_RDATA = 0;
    localparam int OBS_RDOE  = 1;
    localparam int OBS_PAOUT = 2;
    localparam int OBS_PAOE  = 3;
    localparam int OBS_PBOUT = 4;
    localparam int OBS_PBOE  = 5;
    localparam int OBS_PCOUT = 6;
    localparam int OBS_PCOE  = 7;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cs_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1;
    logic [1:0] sel = 2'b00;
    logic [7:0] wdata = 8'h00;
    logic [7:0] rdata;
    logic       rdata_oe;
    logic [7:0] pa_in = 8'h00, pb_in = 8'h00, pc_in = 8'h00;
    logic [7:0] pa_out, pa_oe, pb_out, pb_oe, pc_out, pc_oe;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    typedef struct {
        int         code;
        logic [7:0] val;
        string      req;
    } item_t;

    item_t exp_q[$];

    always #4 clk = ~clk;

    ppio_regs u_ppio_regs (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n),
        .sel(sel), .wdata(wdata), .rdata(rdata), .rdata_oe(rdata_oe),
        .pa_in(pa_in), .pa_out(pa_out), .pa_oe(pa_oe),
        .pb_in(pb_in), .pb_out(pb_out), .pb_oe(pb_oe),
        .pc_in(pc_in), .pc_out(pc_out), .pc_oe(pc_oe)
    );

    function automatic logic [7:0] observe(input int code);
        case (code)
            OBS_RDATA: return rdata;
            OBS_RDOE:  return {7'b0, rdata_oe};
            OBS_PAOUT: return pa_out;
            OBS_PAOE:  return pa_oe;
            OBS_PBOUT: return pb_out;
            OBS_PBOE:  return pb_oe;
            OBS_PCOUT: return pc_out;
            default:   return pc_oe;
        endcase
    endfunction

    // Monitor: compares every queued expectation at the falling edge
    always @(negedge clk) begin
        while (exp_q.size() > 0) begin
            item_t it;
            logic [7:0] act;
            it = exp_q.pop_front();
            act = observe(it.code);
            checks++;
            if (act !== it.val) begin
                failures++;
                $display("FAIL %s obs=%0d actual=0x%02h expected=0x%02h",
                         it.req, it.code, act, it.val);
            end
        end
    end

    task automatic expect_obs(input int code, input logic [7:0] v, input string req);
        item_t it;
        it.code = code; it.val = v; it.req = req;
        exp_q.push_back(it);
    endtask

    task automatic bus_write(input logic [1:0] s, input logic [7:0] d);
        @(posedge clk); #1;
        cs_n = 1'b0; wr_n = 1'b0; sel = s; wdata = d;
        @(posedge clk); #1;
        cs_n = 1'b1; wr_n = 1'b1;
    endtask

    task automatic bus_read(input logic [1:0] s, input logic [7:0] e, input string req);
        @(posedge clk); #1;
        cs_n = 1'b0; rd_n = 1'b0; sel = s;
        expect_obs(OBS_RDATA, e, req);
        expect_obs(OBS_RDOE, 8'h01, req);
        @(posedge clk); #1;
        cs_n = 1'b1; rd_n = 1'b1;
    endtask

    task automatic expect_dirs(input logic [7:0] a, input logic [7:0] b,
                               input logic [7:0] c, input string req);
        expect_obs(OBS_PAOE, a, req);
        expect_obs(OBS_PBOE, b, req);
        expect_obs(OBS_PCOE, c, req);
    endtask

    task automatic settle();
        @(posedge clk); #1;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1 reset state; R4 idle bus
        expect_obs(OBS_PAOUT, 8'h00, "R1");
        expect_obs(OBS_PBOUT, 8'h00, "R1");
        expect_obs(OBS_PCOUT, 8'h00, "R1");
        expect_dirs(8'h00, 8'h00, 8'h00, "R1");
        expect_obs(OBS_RDATA, 8'h00, "R4");
        expect_obs(OBS_RDOE, 8'h00, "R4");
        bus_read(2'b11, 8'h9B, "R1_R11");

        // R9 / R2: all inputs pass pad levels straight through
        pa_in = 8'h3C; pb_in = 8'h5A; pc_in = 8'hE7;
        bus_read(2'b00, 8'h3C, "R2_R9");
        bus_read(2'b01, 8'h5A, "R2_R9");
        bus_read(2'b10, 8'hE7, "R2_R9");

        // R5: 0x8B -> only A output
        bus_write(2'b11, 8'h8B);
        expect_dirs(8'hFF, 8'h00, 8'h00, "R5");
        bus_read(2'b11, 8'h8B, "R11");
        bus_write(2'b00, 8'hA5);
        expect_obs(OBS_PAOUT, 8'hA5, "R2");
        bus_read(2'b00, 8'hA5, "R9");

        // R5 / R6: 0x89 -> A and B outputs, latches cleared
        bus_write(2'b11, 8'h89);
        expect_dirs(8'hFF, 8'hFF, 8'h00, "R5");
        expect_obs(OBS_PAOUT, 8'h00, "R6");
        bus_write(2'b01, 8'h3E);
        expect_obs(OBS_PBOUT, 8'h3E, "R2");

        // R5: 0x99 -> only B output
        bus_write(2'b11, 8'h99);
        expect_dirs(8'h00, 8'hFF, 8'h00, "R5");
        expect_obs(OBS_PBOUT, 8'h00, "R6");

        // R5: 0x81 -> A, B, C upper outputs, C lower input
        bus_write(2'b11, 8'h81);
        expect_dirs(8'hFF, 8'hFF, 8'hF0, "R5");

        // R8 single-line commands
        bus_write(2'b11, 8'h0D);
        expect_obs(OBS_PCOUT, 8'h40, "R8");
        bus_write(2'b11, 8'h05);
        expect_obs(OBS_PCOUT, 8'h44, "R8");
        expect_obs(OBS_PCOE, 8'hF0, "R8");
        pc_in = 8'h0B;
        bus_read(2'b10, 8'h4B, "R9");
        bus_write(2'b11, 8'h0C);
        expect_obs(OBS_PCOUT, 8'h04, "R8");
        bus_write(2'b11, 8'h7F);
        expect_obs(OBS_PCOUT, 8'h84, "R8");
        bus_read(2'b11, 8'h81, "R11");

        // R7 rejected mode words
        bus_write(2'b11, 8'hA0);
        expect_obs(OBS_PCOUT, 8'h84, "R7");
        expect_dirs(8'hFF, 8'hFF, 8'hF0, "R7");
        bus_write(2'b11, 8'h84);
        expect_obs(OBS_PCOUT, 8'h84, "R7");
        bus_read(2'b11, 8'h81, "R7");

        // R2 port C data write
        bus_write(2'b10, 8'h96);
        expect_obs(OBS_PCOUT, 8'h96, "R2");
        bus_read(2'b10, 8'h9B, "R9");

        // R10 write to input port
        bus_write(2'b11, 8'h9B);
        expect_dirs(8'h00, 8'h00, 8'h00, "R5");
        bus_write(2'b00, 8'h77);
        expect_obs(OBS_PAOUT, 8'h77, "R10");
        expect_obs(OBS_PAOE, 8'h00, "R10");
        pa_in = 8'h12;
        bus_read(2'b00, 8'h12, "R10");

        // R3 write without chip select
        @(posedge clk); #1;
        cs_n = 1'b1; wr_n = 1'b0; sel = 2'b01; wdata = 8'hFF;
        settle();
        wr_n = 1'b1;
        expect_obs(OBS_PBOUT, 8'h00, "R3");

        // R3 long strobe with changing data commits only the first
        @(posedge clk); #1;
        cs_n = 1'b0; wr_n = 1'b0; sel = 2'b00; wdata = 8'h11;
        settle(); wdata = 8'h22;
        settle(); wdata = 8'h33;
        settle(); cs_n = 1'b1; wr_n = 1'b1;
        expect_obs(OBS_PAOUT, 8'h11, "R3");

        // R4 read strobe without chip select
        @(posedge clk); #1;
        cs_n = 1'b1; rd_n = 1'b0; sel = 2'b11;
        expect_obs(OBS_RDATA, 8'h00, "R4");
        expect_obs(OBS_RDOE, 8'h00, "R4");
        settle(); rd_n = 1'b1;

        settle();
        @(negedge clk); #1;
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule